// File: doc/BRIEF.md
# Scaled Integer Add Unit

This block is one execution lane of a shader-style integer pipeline. Each issue brings a 64-bit instruction word, a form selector and two 32-bit operands that were already read or extracted upstream. The unit decodes the control fields for the selected form. It optionally negates one operand, or adds one to the second operand instead. It shifts the first operand left by a 5-bit amount and adds the second operand.

The sum, the destination register index and a valid bit are registered one cycle after a valid issue. Zero, sign and carry flags are registered together with a write strobe, but only when the instruction asks for a flag update. Otherwise the flags hold their previous values. The three forms keep the destination index at the same position. They place the flag-enable and shift-amount fields differently, and the 32-bit immediate form has no negate controls.

Top module: `scadd_unit`

## Requirements
- R1: The destination index on `out_dst` is instruction bits [7:0] in every form.
- R2: Form codes on `in_form` are: 0 for register, 1 for 20-bit immediate, 2 for 32-bit immediate, and 3, which decodes like the register form. In forms 0, 1 and 3, bit 47 enables the flag update, bit 49 negates A, bit 48 negates B, and bits [43:39] give the shift amount.
- R3: In form 2, bit 52 enables the flag update and bits [57:53] give the shift amount. Bits 47, 48 and 49 have no effect, and neither operand is negated.
- R4: The result is (A' << shift) + B' truncated to 32 bits. A shift of 0 passes A' through unchanged, and zeros enter from the right for shifts up to 31.
- R5: With exactly one negate bit set, that operand is replaced by its two's complement. For A this happens before the shift.
- R6: With both negate bits set, neither operand is negated and B' = B + 1 (mod 2^32).
- R7: On a flagged issue, zero is set when the result is all zeros, sign equals result bit 31, and carry is bit 32 of the 33-bit sum of the shifted A' and B'.
- R8: When an issue has its flag update disabled, or when no issue occurs, `out_flag_wr` is low in the following cycle and the three flags keep their values.
- R9: `out_valid`, `out_result` and `out_dst` are registered one cycle after `in_valid`. Without a valid issue, `out_valid` is low and the result and index hold.
- R10: Synchronous active-high reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue qualifier |
| in_form | input | 2 | Form selector (0 reg, 1 imm20, 2 imm32, 3 as reg) |
| in_insn | input | 64 | Instruction word |
| in_opa | input | 32 | First operand A (scaled) |
| in_opb | input | 32 | Second operand B |
| out_valid | output | 1 | Result valid, one cycle after issue |
| out_dst | output | 8 | Destination register index |
| out_result | output | 32 | Scaled sum |
| out_flag_wr | output | 1 | Flags were updated this cycle |
| out_zero | output | 1 | Zero flag |
| out_sign | output | 1 | Sign flag |
| out_carry | output | 1 | Carry flag |

## Verification
A decode slip, such as a field read from the wrong form's position, shows up as a wrong sum or a wrong flag strobe. It appears on the registered outputs in the cycle right after the offending issue. A broken plus-one or negate path changes the sum by a fixed offset or a sign, and only for the matching negate combinations. The sweep therefore crosses every form with every negate pair and every shift amount. A flag register that updates when it should hold stays wrong until the next flagged issue, so the bench checks the held flags on every unflagged issue and on idle cycles.

// File: rtl/scadd_pkg.sv
package scadd_pkg;
    parameter int DATA_W  = 32;
    parameter int INSN_W  = 64;
    parameter int REG_W   = 8;
    parameter int SHAMT_W = 5;

    // field positions shared by the forms
    localparam int DST_LSB    = 0;
    localparam int RI_CC_BIT  = 47;
    localparam int RI_NB_BIT  = 48;
    localparam int RI_NA_BIT  = 49;
    localparam int RI_SH_LSB  = 39;
    localparam int I32_CC_BIT = 52;
    localparam int I32_SH_LSB = 53;

    typedef enum logic [1:0] {
        FORM_REG   = 2'd0,
        FORM_IMM20 = 2'd1,
        FORM_IMM32 = 2'd2,
        FORM_RSVD  = 2'd3
    } form_e;

    typedef struct packed {
        logic [REG_W-1:0]   dst;
        logic               flag_en;
        logic               neg_a;
        logic               neg_b;
        logic [SHAMT_W-1:0] shamt;
    } ctrl_t;

    typedef struct packed {
        logic zero;
        logic sign;
        logic carry;
    } flags_t;

    function automatic flags_t make_flags(input logic [DATA_W-1:0] sum, input logic cout);
        flags_t f;
        f.zero  = (sum == '0);
        f.sign  = sum[DATA_W-1];
        f.carry = cout;
        return f;
    endfunction
endpackage

// File: rtl/scadd_decode.sv
module scadd_decode
    import scadd_pkg::*;
(
    input  form_e             form,
    input  logic [INSN_W-1:0] insn,
    output ctrl_t             ctrl
);
    always_comb begin
        ctrl.dst = insn[DST_LSB +: REG_W];
        if (form == FORM_IMM32) begin
            ctrl.flag_en = insn[I32_CC_BIT];
            ctrl.shamt   = insn[I32_SH_LSB +: SHAMT_W];
            ctrl.neg_a   = 1'b0;
            ctrl.neg_b   = 1'b0;
        end else begin
            ctrl.flag_en = insn[RI_CC_BIT];
            ctrl.shamt   = insn[RI_SH_LSB +: SHAMT_W];
            ctrl.neg_a   = insn[RI_NA_BIT];
            ctrl.neg_b   = insn[RI_NB_BIT];
        end
    end
endmodule

// File: rtl/scadd_alu.sv
module scadd_alu
    import scadd_pkg::*;
(
    input  ctrl_t             ctrl,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] sum,
    output logic              cout
);
    logic              plus_one;
    logic [DATA_W-1:0] a_p, b_p, scaled;

    always_comb begin
        plus_one = ctrl.neg_a & ctrl.neg_b;
        a_p      = (ctrl.neg_a & ~ctrl.neg_b) ? (~opa + 1'b1) : opa;
        if (plus_one)
            b_p = opb + 1'b1;
        else if (ctrl.neg_b)
            b_p = ~opb + 1'b1;
        else
            b_p = opb;
        scaled      = a_p << ctrl.shamt;
        {cout, sum} = {1'b0, scaled} + {1'b0, b_p};
    end
endmodule

// File: rtl/scadd_unit.sv
module scadd_unit
    import scadd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        in_form,
    input  logic [INSN_W-1:0] in_insn,
    input  logic [DATA_W-1:0] in_opa,
    input  logic [DATA_W-1:0] in_opb,
    output logic              out_valid,
    output logic [REG_W-1:0]  out_dst,
    output logic [DATA_W-1:0] out_result,
    output logic              out_flag_wr,
    output logic              out_zero,
    output logic              out_sign,
    output logic              out_carry
);
    ctrl_t             ctrl;
    logic [DATA_W-1:0] sum;
    logic              cout;
    flags_t            flags_q;

    scadd_decode u_dec (
        .form (form_e'(in_form)),
        .insn (in_insn),
        .ctrl (ctrl)
    );

    scadd_alu u_alu (
        .ctrl (ctrl),
        .opa  (in_opa),
        .opb  (in_opb),
        .sum  (sum),
        .cout (cout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_dst     <= '0;
            out_result  <= '0;
            out_flag_wr <= 1'b0;
            flags_q     <= '0;
        end else begin
            out_valid   <= in_valid;
            out_flag_wr <= in_valid & ctrl.flag_en;
            if (in_valid) begin
                out_dst    <= ctrl.dst;
                out_result <= sum;
                if (ctrl.flag_en)
                    flags_q <= make_flags(sum, cout);
            end
        end
    end

    assign out_zero  = flags_q.zero;
    assign out_sign  = flags_q.sign;
    assign out_carry = flags_q.carry;

    // R7
    sign_tracks_result_chk: assert property (@(posedge clk) disable iff (rst)
        out_flag_wr |-> (out_sign == out_result[DATA_W-1]));

    // R7
    zero_tracks_result_chk: assert property (@(posedge clk) disable iff (rst)
        out_flag_wr |-> (out_zero == (out_result == '0)));

    // R8
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_flag_wr |-> $stable({out_zero, out_sign, out_carry}));

    // R8
    flag_wr_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_flag_wr |-> out_valid);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_result) && $stable(out_dst)));

    // R9
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
endmodule

// File: tb/sim_scadd_unit.sv
`timescale 1ns/1ps
module sim_scadd_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  in_form;
    logic [63:0] in_insn;
    logic [31:0] in_opa, in_opb;
    logic        out_valid, out_flag_wr, out_zero, out_sign, out_carry;
    logic [7:0]  out_dst;
    logic [31:0] out_result;

    int n_chk  = 0;
    int n_fail = 0;
    logic [2:0] exp_flags;
    logic [31:0] last_res;
    logic [7:0]  last_dst;

    always #2 clk = ~clk;

    scadd_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_form(in_form),
        .in_insn(in_insn), .in_opa(in_opa), .in_opb(in_opb),
        .out_valid(out_valid), .out_dst(out_dst), .out_result(out_result),
        .out_flag_wr(out_flag_wr), .out_zero(out_zero), .out_sign(out_sign),
        .out_carry(out_carry)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one issue: drive at negedge, check at the following negedge
    task automatic issue(input logic [1:0] form, input logic [63:0] insn,
                         input logic [31:0] a, input logic [31:0] b);
        logic        fe, na, nb;
        logic [4:0]  sh;
        logic [31:0] ap, bp, sc;
        logic [32:0] full;
        string       rq;
        if (form == 2'd2) begin
            fe = insn[52]; sh = insn[57:53]; na = 1'b0; nb = 1'b0;
        end else begin
            fe = insn[47]; sh = insn[43:39]; na = insn[49]; nb = insn[48];
        end
        ap = a; bp = b; rq = "R4";
        if (na && nb) begin bp = b + 32'd1; rq = "R6"; end
        else if (na) begin ap = -a; rq = "R5"; end
        else if (nb) begin bp = -b; rq = "R5"; end
        sc   = ap << sh;
        full = {1'b0, sc} + {1'b0, bp};
        in_valid = 1'b1; in_form = form; in_insn = insn; in_opa = a; in_opb = b;
        @(negedge clk);
        in_valid = 1'b0;
        if (fe) exp_flags = {(full[31:0] == 32'd0), full[31], full[32]};
        chk(rq, out_result, full[31:0]);
        chk("R1", out_dst, insn[7:0]);
        chk("R9", out_valid, 1);
        chk(form == 2'd2 ? "R3 flag enable" : "R2 flag enable", out_flag_wr, fe);
        chk(fe ? "R7" : "R8", {out_zero, out_sign, out_carry}, exp_flags);
        last_res = full[31:0];
        last_dst = insn[7:0];
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] pa [4];
        logic [31:0] pb [4];
        logic [63:0] w;
        pa[0] = 32'h0000_0001; pb[0] = 32'h0000_0000;
        pa[1] = 32'hFFFF_FFFF; pb[1] = 32'h0000_0001;
        pa[2] = 32'h8000_0000; pb[2] = 32'h8000_0000;
        pa[3] = 32'h1234_5678; pb[3] = 32'hFFFF_FFFF;
        rst = 1'b1; in_valid = 1'b0; in_form = 2'd0; in_insn = '0; in_opa = '0; in_opb = '0;
        exp_flags = 3'b000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk("R10", {out_valid, out_flag_wr, out_zero, out_sign, out_carry}, 0);
        chk("R10", {out_dst, out_result}, 0);
        last_res = '0; last_dst = '0;

        for (int f = 0; f < 4; f++)
            for (int n = 0; n < 4; n++)
                for (int s = 0; s < 32; s++)
                    for (int p = 0; p < 4; p++) begin
                        w = {$urandom, $urandom};
                        if (f == 2) begin
                            w[52]    = (((s + p) % 3) != 0);
                            w[57:53] = s[4:0];
                            w[49:48] = n[1:0];   // noise: no effect in R3
                        end else begin
                            w[47]    = (((s + p) % 3) != 0);
                            w[49]    = n[1];
                            w[48]    = n[0];
                            w[43:39] = s[4:0];
                        end
                        issue(f[1:0], w, pa[p], (p == 0 && n == 3) ? 32'hFFFF_FFFF : pb[p]);
                    end

        // R9 and R8: idle cycle holds result, index and flags
        in_opa = 32'hDEAD_BEEF; in_insn = {64{1'b1}};
        @(negedge clk);
        chk("R9 idle valid", out_valid, 0);
        chk("R9 idle hold", {out_dst, out_result}, {last_dst, last_res});
        chk("R8 idle strobe", out_flag_wr, 0);
        chk("R8 idle flags", {out_zero, out_sign, out_carry}, exp_flags);

        // R4 explicit: shift 31 brings in zeros, A=3 -> 0x80000000
        w = '0; w[43:39] = 5'd31; w[47] = 1'b1; w[7:0] = 8'hA5;
        issue(2'd0, w, 32'h3, 32'h0);
        chk("R4 shift31", out_result, 32'h8000_0000);
        // R6: both negates, B=0xFFFFFFFF wraps to 0, A=0 -> zero flag
        w = '0; w[49:47] = 3'b111;
        issue(2'd1, w, 32'h0, 32'hFFFF_FFFF);
        chk("R6 wrap zero", {out_result, out_zero}, {32'h0, 1'b1});

        // R10 reset again clears
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk("R10 rerun", {out_valid, out_zero, out_sign, out_carry, out_result}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule